// File: doc/BRIEF.md
# Non-Blocking Load Miss Buffer

This block sits beside the first-level data cache and takes in loads that missed it. Each miss goes into an ordered queue, so the issue stage keeps running without waiting for the data. The queue sends the misses one per cycle to a pipelined second-level cache. That cache answers in order after a fixed three-cycle latency. The returning data passes through an alignment pipeline and is then written back with its destination register.

A pending-register scoreboard holds one bit per architectural register. A bit is set when a miss to that register is queued and cleared in the cycle its data is written back. The block raises `stall` only in these cases:
- an issuing instruction reads a register that is still pending;
- a new miss targets a register that is still pending;
- the queue is full and nothing leaves it that cycle.

A parameter selects the cache timing mode. That mode sets the alignment depth, so an immediate use of a missing load stalls for 7 cycles in the 1-1-1 mode or 8 cycles in the 2-2 mode.

Top module: `lmb_miss_buffer`

## Requirements
- R1: A miss offered on `miss_valid` with room in the queue and no hazard is accepted in that cycle with `stall` low; one miss per cycle is accepted back to back.
- R2: Accepted misses are presented on `l2_req_valid`/`l2_req_addr` strictly in arrival order, one per cycle, the first one in the cycle after acceptance when the queue held no unsent entry.
- R3: `stall` is high when an enabled source register (`use_rs1`, `use_rs2`) is pending, and low when no input names a pending register and the queue is not blocking.
- R4: Write-backs occur in arrival order; `wb_reg` is the miss's destination and `wb_data` the matching response data. `wb_valid` rises exactly 4 cycles after the response in mode MODE_111 (encoding 0) and 5 cycles after it in mode MODE_22 (encoding 1).
- R5: A use issued in the cycle right after its miss is accepted stalls for exactly 7 cycles in MODE_111 and exactly 8 cycles in MODE_22.
- R6: In MODE_111 with DEPTH 8, back-to-back misses are all accepted, and a use issued 8 cycles after its load never stalls.
- R7: A pending bit clears in the cycle its write-back is presented, and a use of that register does not stall in that cycle.
- R8: With DEPTH misses outstanding and no write-back in the cycle, a further miss raises `stall` and is not accepted; it is accepted in the first cycle a write-back frees an entry.
- R9: A miss whose destination register is still pending raises `stall` and is held until that register's earlier write-back.
- R10: Reset empties the queue and clears every pending bit: during and after reset `stall`, `l2_req_valid` and `wb_valid` are low, and a use of a previously pending register does not stall.
- R11: A source register whose enable is low has no effect on `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| miss_valid | input | 1 | A load missed the first-level cache this cycle |
| miss_reg | input | RW ($clog2(NREG)) | Destination register of the missing load |
| miss_addr | input | AW | Address of the missing load |
| use_rs1_en | input | 1 | First source of the issuing instruction is read |
| use_rs1 | input | RW | First source register number |
| use_rs2_en | input | 1 | Second source of the issuing instruction is read |
| use_rs2 | input | RW | Second source register number |
| stall | output | 1 | Hold the issuing group this cycle |
| l2_req_valid | output | 1 | Request to the second-level cache |
| l2_req_addr | output | AW | Request address |
| l2_resp_valid | input | 1 | In-order response from the second-level cache |
| l2_resp_data | input | DW | Response data |
| wb_valid | output | 1 | Write-back strobe |
| wb_reg | output | RW | Write-back destination register |
| wb_data | output | DW | Write-back data |

## Verification
The bound checker watches several properties on every cycle:
- stall never rises without a use or a miss present;
- outstanding misses never exceed the depth, and a full queue blocks a further miss;
- every request is backed by an unsent accepted miss;
- each write-back follows a response by exactly the alignment depth.

Other behaviours show only in the bench's scenarios:
- the exact stall lengths per mode;
- the no-stall use eight cycles after its load under back-to-back misses;
- the ordered register and data pairing;
- the hold of a second miss to a pending register;
- the scoreboard being cleared by a reset taken mid-flight.

// File: rtl/lmb_pkg.sv
package lmb_pkg;

  typedef enum logic {
    MODE_111 = 1'b0,
    MODE_22  = 1'b1
  } sram_mode_e;

  // Second-level cache request-to-data latency, both modes.
  localparam int L2_LAT   = 3;
  // Alignment stages after the response in the fast mode.
  localparam int BASE_RET = 4;

  function automatic int ret_stages(input sram_mode_e m);
    return BASE_RET + ((m == MODE_22) ? 1 : 0);
  endfunction

endpackage

// File: rtl/lmb_queue.sv
module lmb_queue #(
  parameter int DEPTH = 8,
  parameter int RW    = 5,
  parameter int AW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [RW-1:0] push_reg_i,
  input  logic [AW-1:0] push_addr_i,
  output logic          issue_o,
  output logic [AW-1:0] issue_addr_o,
  input  logic          retire_i,
  output logic [RW-1:0] retire_reg_o,
  output logic          full_o
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [RW-1:0] reg_mem  [DEPTH];
  logic [AW-1:0] addr_mem [DEPTH];

  logic [PW-1:0] wr_q, wr_d, iss_q, iss_d, ret_q, ret_d;
  logic [CW-1:0] occ_q, occ_d, uns_q, uns_d;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign issue_o      = (uns_q != '0);
  assign issue_addr_o = addr_mem[iss_q];
  assign retire_reg_o = reg_mem[ret_q];
  assign full_o       = (occ_q == CW'(DEPTH));

  always_comb begin
    wr_d  = push_i   ? bump(wr_q)  : wr_q;
    iss_d = issue_o  ? bump(iss_q) : iss_q;
    ret_d = retire_i ? bump(ret_q) : ret_q;
    occ_d = occ_q + CW'(push_i) - CW'(retire_i);
    uns_d = uns_q + CW'(push_i) - CW'(issue_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      iss_q <= '0;
      ret_q <= '0;
      occ_q <= '0;
      uns_q <= '0;
    end else begin
      wr_q  <= wr_d;
      iss_q <= iss_d;
      ret_q <= ret_d;
      occ_q <= occ_d;
      uns_q <= uns_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) begin
      reg_mem[wr_q]  <= push_reg_i;
      addr_mem[wr_q] <= push_addr_i;
    end
  end

endmodule

// File: rtl/lmb_scoreboard.sv
module lmb_scoreboard #(
  parameter int NREG = 32,
  parameter int RW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_i,
  input  logic [RW-1:0]   set_reg_i,
  input  logic            clr_i,
  input  logic [RW-1:0]   clr_reg_i,
  output logic [NREG-1:0] live_o
);

  logic [NREG-1:0] pend_q, pend_d, set_mask, clr_mask;

  always_comb begin
    set_mask = '0;
    clr_mask = '0;
    if (set_i) set_mask[set_reg_i] = 1'b1;
    if (clr_i) clr_mask[clr_reg_i] = 1'b1;
    live_o = pend_q & ~clr_mask;
    pend_d = live_o | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

endmodule

// File: rtl/lmb_return_pipe.sv
module lmb_return_pipe #(
  parameter int STAGES = 4,
  parameter int DW     = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);

  for (genvar g = 0; g < STAGES; g++) begin : g_stg
    logic          v_in, v_q;
    logic [DW-1:0] d_in, d_q;

    if (g == 0) begin : g_head
      assign v_in = in_valid;
      assign d_in = in_data;
    end else begin : g_body
      assign v_in = g_stg[g-1].v_q;
      assign d_in = g_stg[g-1].d_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_in;
    end

    always_ff @(posedge clk) begin
      if (v_in) d_q <= d_in;
    end
  end

  assign out_valid = g_stg[STAGES-1].v_q;
  assign out_data  = g_stg[STAGES-1].d_q;

endmodule

// File: rtl/lmb_miss_buffer.sv
module lmb_miss_buffer #(
  parameter int                 DEPTH = 8,
  parameter int                 NREG  = 32,
  parameter int                 AW    = 32,
  parameter int                 DW    = 64,
  parameter lmb_pkg::sram_mode_e MODE = lmb_pkg::MODE_111,
  localparam int                RW    = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss_valid,
  input  logic [RW-1:0] miss_reg,
  input  logic [AW-1:0] miss_addr,
  input  logic          use_rs1_en,
  input  logic [RW-1:0] use_rs1,
  input  logic          use_rs2_en,
  input  logic [RW-1:0] use_rs2,
  output logic          stall,
  output logic          l2_req_valid,
  output logic [AW-1:0] l2_req_addr,
  input  logic          l2_resp_valid,
  input  logic [DW-1:0] l2_resp_data,
  output logic          wb_valid,
  output logic [RW-1:0] wb_reg,
  output logic [DW-1:0] wb_data
);

  localparam int RET_STAGES = lmb_pkg::ret_stages(MODE);

  logic            full, accept, hazard, blocked;
  logic [NREG-1:0] live;

  // Hazard uses the scoreboard after this cycle's write-back clear.
  always_comb begin
    hazard  = (use_rs1_en & live[use_rs1])
            | (use_rs2_en & live[use_rs2])
            | (miss_valid & live[miss_reg]);
    blocked = miss_valid & full & ~wb_valid;
    stall   = hazard | blocked;
    accept  = miss_valid & ~stall;
  end

  lmb_queue #(.DEPTH(DEPTH), .RW(RW), .AW(AW)) u_queue (
    .clk          (clk),
    .rst_n        (rst_n),
    .push_i       (accept),
    .push_reg_i   (miss_reg),
    .push_addr_i  (miss_addr),
    .issue_o      (l2_req_valid),
    .issue_addr_o (l2_req_addr),
    .retire_i     (wb_valid),
    .retire_reg_o (wb_reg),
    .full_o       (full)
  );

  lmb_scoreboard #(.NREG(NREG), .RW(RW)) u_score (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_i     (accept),
    .set_reg_i (miss_reg),
    .clr_i     (wb_valid),
    .clr_reg_i (wb_reg),
    .live_o    (live)
  );

  lmb_return_pipe #(.STAGES(RET_STAGES), .DW(DW)) u_ret (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (l2_resp_valid),
    .in_data   (l2_resp_data),
    .out_valid (wb_valid),
    .out_data  (wb_data)
  );

endmodule

// File: rtl/lmb_checker.sv
module lmb_checker #(
  parameter int DEPTH = 8,
  parameter int RET   = 4
) (
  input logic clk,
  input logic rst_n,
  input logic miss_valid,
  input logic stall,
  input logic use_rs1_en,
  input logic use_rs2_en,
  input logic l2_req_valid,
  input logic l2_resp_valid,
  input logic wb_valid
);

  logic [RET-1:0] resp_hist;
  logic [31:0]    outst, unsent;
  logic           acc;

  assign acc = miss_valid & ~stall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_hist <= '0;
      outst     <= '0;
      unsent    <= '0;
    end else begin
      resp_hist <= {resp_hist[RET-2:0], l2_resp_valid};
      outst     <= outst + 32'(acc) - 32'(wb_valid);
      unsent    <= unsent + 32'(acc) - 32'(l2_req_valid);
    end
  end

  assert_stall_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(use_rs1_en || use_rs2_en || miss_valid) |-> !stall);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    outst <= 32'(DEPTH));

  assert_full_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && outst == 32'(DEPTH) && !wb_valid) |-> stall);

  assert_req_backed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    l2_req_valid |-> unsent != 32'd0);

  assert_wb_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid == resp_hist[RET-1]);

  assert_wb_backed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> outst != 32'd0);

endmodule

bind lmb_miss_buffer lmb_checker #(.DEPTH(DEPTH), .RET(RET_STAGES)) u_lmb_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .miss_valid    (miss_valid),
  .stall         (stall),
  .use_rs1_en    (use_rs1_en),
  .use_rs2_en    (use_rs2_en),
  .l2_req_valid  (l2_req_valid),
  .l2_resp_valid (l2_resp_valid),
  .wb_valid      (wb_valid)
);

// File: tb/tb_lmb_miss_buffer.sv
`timescale 1ns/1ps

module tb_l2_model #(
  parameter int LAT = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_addr,
  output logic        resp_valid,
  output logic [63:0] resp_data
);
  logic [LAT-1:0] v;
  logic [63:0]    d [LAT];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) v <= '0;
    else        v <= {v[LAT-2:0], req_valid};
  end

  always @(posedge clk) begin
    d[0] <= {req_addr ^ 32'h5A5A_C3C3, req_addr};
    for (int i = 1; i < LAT; i++) d[i] <= d[i-1];
  end

  assign resp_valid = v[LAT-1];
  assign resp_data  = d[LAT-1];
endmodule

module tb_lmb_miss_buffer;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;

  // fast-mode instance
  logic        miss_valid, rs1_en, rs2_en;
  logic [4:0]  miss_reg, rs1, rs2;
  logic [31:0] miss_addr;
  logic        stall, l2_req_valid, l2_resp_valid, wb_valid;
  logic [31:0] l2_req_addr;
  logic [63:0] l2_resp_data, wb_data;
  logic [4:0]  wb_reg;

  // slow-mode instance
  logic        b_miss_valid, b_rs1_en;
  logic [4:0]  b_miss_reg, b_rs1;
  logic [31:0] b_miss_addr;
  logic        b_stall, b_req_valid, b_resp_valid, b_wb_valid;
  logic [31:0] b_req_addr;
  logic [63:0] b_resp_data, b_wb_data;
  logic [4:0]  b_wb_reg;

  lmb_miss_buffer dut (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_reg(miss_reg), .miss_addr(miss_addr),
    .use_rs1_en(rs1_en), .use_rs1(rs1), .use_rs2_en(rs2_en), .use_rs2(rs2),
    .stall(stall), .l2_req_valid(l2_req_valid), .l2_req_addr(l2_req_addr),
    .l2_resp_valid(l2_resp_valid), .l2_resp_data(l2_resp_data),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_data(wb_data)
  );

  tb_l2_model #(.LAT(3)) u_l2 (
    .clk(clk), .rst_n(rst_n), .req_valid(l2_req_valid), .req_addr(l2_req_addr),
    .resp_valid(l2_resp_valid), .resp_data(l2_resp_data)
  );

  lmb_miss_buffer #(.MODE(lmb_pkg::MODE_22)) dut1 (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(b_miss_valid), .miss_reg(b_miss_reg), .miss_addr(b_miss_addr),
    .use_rs1_en(b_rs1_en), .use_rs1(b_rs1), .use_rs2_en(1'b0), .use_rs2(5'd0),
    .stall(b_stall), .l2_req_valid(b_req_valid), .l2_req_addr(b_req_addr),
    .l2_resp_valid(b_resp_valid), .l2_resp_data(b_resp_data),
    .wb_valid(b_wb_valid), .wb_reg(b_wb_reg), .wb_data(b_wb_data)
  );

  tb_l2_model #(.LAT(3)) u_l2b (
    .clk(clk), .rst_n(rst_n), .req_valid(b_req_valid), .req_addr(b_req_addr),
    .resp_valid(b_resp_valid), .resp_data(b_resp_data)
  );

  logic [68:0] exp_q [$];
  logic [31:0] addr_q [$];
  logic [68:0] mon_e;
  logic [31:0] mon_a;

  function automatic logic [63:0] l2_data(input logic [31:0] a);
    return {a ^ 32'h5A5A_C3C3, a};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: settle after driving, then record what the design accepts
  task automatic settle();
    #2;
    if (rst_n && miss_valid && !stall) begin
      exp_q.push_back({miss_reg, l2_data(miss_addr)});
      addr_q.push_back(miss_addr);
    end
  endtask

  task automatic idle_inputs();
    miss_valid = 0; miss_reg = 0; miss_addr = 0;
    rs1_en = 0; rs1 = 0; rs2_en = 0; rs2 = 0;
    b_miss_valid = 0; b_miss_reg = 0; b_miss_addr = 0; b_rs1_en = 0; b_rs1 = 0;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); idle_inputs(); settle();
    end
  endtask

  // monitor: pop and compare as the design produces requests and write-backs
  always @(negedge clk) begin
    #3;
    if (rst_n && l2_req_valid) begin
      if (addr_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R2 actual req %0h expected none", l2_req_addr);
      end else begin
        mon_a = addr_q.pop_front();
        check("R2 request order", {32'd0, l2_req_addr}, {32'd0, mon_a});
      end
    end
    if (rst_n && wb_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_err++;
        $display("FAIL R4 actual wb reg %0d expected none", wb_reg);
      end else begin
        mon_e = exp_q.pop_front();
        check("R4 wb reg", {59'd0, wb_reg}, {59'd0, mon_e[68:64]});
        check("R4 wb data", wb_data, mon_e[63:0]);
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    int d0, d1;
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    #2;
    check("R10 reset stall", {63'd0, stall}, 64'd0);
    check("R10 reset req", {63'd0, l2_req_valid}, 64'd0);
    check("R10 reset wb", {63'd0, wb_valid}, 64'd0);
    @(negedge clk); rst_n = 1'b1;
    idle_cycles(2);

    // R5 / R7 / R2: immediate use, both modes
    @(negedge clk);
    miss_valid = 1; miss_reg = 5; miss_addr = 32'h1000;
    b_miss_valid = 1; b_miss_reg = 5; b_miss_addr = 32'h1000;
    settle();
    check("R1 miss accepted", {63'd0, stall}, 64'd0);
    check("R1 miss accepted mode22", {63'd0, b_stall}, 64'd0);
    d0 = -1; d1 = -1;
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      miss_valid = 0; b_miss_valid = 0;
      rs1_en = 1; rs1 = 5; b_rs1_en = 1; b_rs1 = 5;
      settle();
      if (i == 1) begin
        check("R2 req next cycle", {63'd0, l2_req_valid}, 64'd1);
        check("R2 req addr", {32'd0, l2_req_addr}, 64'h1000);
      end
      if (d0 < 0 && !stall) begin
        d0 = i;
        check("R7 wb in drop cycle", {58'd0, wb_valid, wb_reg}, {58'd0, 1'b1, 5'd5});
      end
      if (d1 < 0 && !b_stall) d1 = i;
    end
    check("R5 stall cycles mode111", 64'(d0 - 1), 64'd7);
    check("R5 stall cycles mode22", 64'(d1 - 1), 64'd8);
    idle_cycles(12);

    // R6 / R1: back-to-back misses, uses 8 cycles later
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      idle_inputs();
      miss_valid = 1; miss_reg = 5'(k + 1); miss_addr = 32'h2000 + 32'(k * 4);
      if (k >= 8) begin rs1_en = 1; rs1 = 5'(k - 7); end
      settle();
      check("R6 no stall back-to-back", {63'd0, stall}, 64'd0);
    end
    idle_cycles(12);

    // R11 / R3: enables and matching
    @(negedge clk); idle_inputs();
    miss_valid = 1; miss_reg = 9; miss_addr = 32'h3000;
    settle();
    @(negedge clk); idle_inputs();
    rs1_en = 0; rs1 = 9; rs2_en = 1; rs2 = 12;
    settle();
    check("R11 disabled source ignored", {63'd0, stall}, 64'd0);
    @(negedge clk); idle_inputs();
    rs2_en = 1; rs2 = 9;
    settle();
    check("R3 rs2 pending stalls", {63'd0, stall}, 64'd1);
    @(negedge clk); idle_inputs();
    rs1_en = 1; rs1 = 9; rs2_en = 0; rs2 = 9;
    settle();
    check("R3 rs1 pending stalls", {63'd0, stall}, 64'd1);
    idle_cycles(10);
    @(negedge clk); idle_inputs();
    rs1_en = 1; rs1 = 9;
    settle();
    check("R3 cleared no stall", {63'd0, stall}, 64'd0);
    idle_cycles(2);

    // R8: full queue in mode 2-2
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); idle_inputs();
      b_miss_valid = 1; b_miss_reg = 5'(20 + ((k < 8) ? k : 8));
      b_miss_addr = 32'h6000 + 32'(k * 4);
      settle();
      if (k < 8) check("R8 accept below depth", {63'd0, b_stall}, 64'd0);
      else if (k == 8) check("R8 full stalls", {63'd0, b_stall}, 64'd1);
      else check("R8 accepted on free", {63'd0, b_stall}, 64'd0);
    end
    idle_cycles(14);

    // R9: second miss to a pending register
    @(negedge clk); idle_inputs();
    miss_valid = 1; miss_reg = 7; miss_addr = 32'h4000;
    settle();
    d0 = -1;
    for (int i = 1; i <= 10; i++) begin
      @(negedge clk); idle_inputs();
      if (d0 < 0) begin miss_valid = 1; miss_reg = 7; miss_addr = 32'h4004; end
      settle();
      if (i == 1) check("R9 pending dest stalls", {63'd0, stall}, 64'd1);
      if (d0 < 0 && miss_valid && !stall) d0 = i;
    end
    check("R9 accepted at first wb", 64'(d0), 64'd8);
    idle_cycles(12);

    // R10: reset mid-flight
    @(negedge clk); idle_inputs();
    miss_valid = 1; miss_reg = 3; miss_addr = 32'h5000;
    settle();
    idle_cycles(2);
    @(negedge clk); idle_inputs();
    rst_n = 1'b0;
    exp_q.delete(); addr_q.delete();
    rs1_en = 1; rs1 = 3;
    #2;
    check("R10 reset stall", {63'd0, stall}, 64'd0);
    check("R10 reset req", {63'd0, l2_req_valid}, 64'd0);
    check("R10 reset wb", {63'd0, wb_valid}, 64'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    settle();
    @(negedge clk); rs1_en = 1; rs1 = 3; settle();
    check("R10 scoreboard cleared", {63'd0, stall}, 64'd0);
    idle_cycles(12);

    check("R4 all written back", 64'(exp_q.size()), 64'd0);
    finish_run();
  end

endmodule